// File: doc/BRIEF.md
# SIMD Divergence Mask Controller

This block keeps the per-lane execution mask of a SIMD core that runs structured branches and loops. The sequencer sends one control opcode per cycle, together with a per-lane condition vector. The block narrows, flips or restores the active lane mask. It also tells the sequencer when a branch body or a loop has no live lane left, so that the body can be jumped over. The mask gates register writes in the datapath.

Nesting is held on an internal frame stack of parameterized depth. Each frame keeps the mask that was live before the construct opened, plus the set of lanes waiting for the alternative branch. Stack misuse raises a sticky error flag. A misused opcode leaves the mask and the stack untouched. Reset clears the error flag.

Top module: `simd_mask_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every lane is active, the stack is empty, `stack_err` is 0, and all skip outputs are 0.
- R2: On opcode 1 (branch open), the next-cycle mask is the current mask AND `cond`, and a frame is pushed.
- R3: During the branch-open cycle, `skip_if` is 1 exactly when the current mask AND `cond` is zero. `skip_if` is 0 on every other opcode.
- R4: On opcode 2 (branch flip), the next-cycle mask is the saved parent mask AND the inverse of the condition captured at branch open. `cond` is ignored in this cycle.
- R5: During the branch-flip cycle, `skip_else` is 1 exactly when that flipped mask is zero. `skip_else` is 0 on every other opcode.
- R6: On opcode 3 (branch close), the mask returns to its value before the matching branch open, and the frame is popped.
- R7: Constructs nest up to DEPTH frames, and each close restores its own level's mask.
- R8: Opcode 4 (loop enter) pushes a frame and leaves the mask unchanged. Opcode 5 (loop test) sets the mask to the current mask AND `cond`. `loop_exit` is 1 in that cycle exactly when the result is zero, and is 0 on every other opcode.
- R9: On opcode 6 (loop close), the mask returns to its value at loop enter, and the frame is popped.
- R10: A push (opcode 1 or 4) onto a full stack sets `stack_err` until reset and changes neither the mask nor the stack. `skip_if` is still evaluated in that cycle.
- R11: Opcode 2, 3 or 6 on an empty stack sets `stack_err` and leaves the mask unchanged.
- R12: Opcode 0 (and the unused code 7) changes nothing and drives all skip outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op | input | 3 | Control opcode (0 to 6) |
| cond | input | LANES | Per-lane condition vector |
| active_mask | output | LANES | Current lane enable mask |
| skip_if | output | 1 | No live lane enters the branch body |
| skip_else | output | 1 | No live lane enters the alternative body |
| loop_exit | output | 1 | No lane remains in the loop |
| stack_err | output | 1 | Sticky overflow or underflow flag |

## Verification
A branch open that lands on a full stack does two things in one cycle. It reports the same-cycle skip decision, and it raises the overflow error while freezing the mask. To provoke this, the bench nests DEPTH+1 openings. It does so once with a condition of zero, so that `skip_if` is due while the push is refused. It then checks that both outputs match the reference model and that the mask keeps its old value. Randomized nested sequences are compared lane by lane against that model every cycle.

// File: rtl/simd_mask_pkg.sv
// Package: opcode encoding shared by the mask controller and its parts.
package simd_mask_pkg;
    typedef enum logic [2:0] {
        OP_NOP        = 3'd0,
        OP_IF         = 3'd1,
        OP_ELSE       = 3'd2,
        OP_ENDIF      = 3'd3,
        OP_LOOP_ENTER = 3'd4,
        OP_LOOP_TEST  = 3'd5,
        OP_LOOP_END   = 3'd6
    } mask_op_e;
endpackage

// File: rtl/simd_mask_stack.sv
// Module: frame stack holding a parent mask and an alternative mask per level.
// Assumes: push and pop are never raised together; push on full and pop on
// empty are ignored here (the caller flags them).
module simd_mask_stack #(
    parameter int LANES = 16,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [LANES-1:0] push_par,
    input  logic [LANES-1:0] push_alt,
    output logic [LANES-1:0] top_par,
    output logic [LANES-1:0] top_alt,
    output logic             full,
    output logic             empty
);
    localparam int PW = $clog2(DEPTH + 1);

    logic [PW-1:0]    ptr_q;
    logic [LANES-1:0] par_q [DEPTH];
    logic [LANES-1:0] alt_q [DEPTH];

    assign full  = (ptr_q == PW'(DEPTH));
    assign empty = (ptr_q == '0);

    // Track the number of occupied frames.
    always_ff @(posedge clk) begin
        if (!rst_n)                ptr_q <= '0;
        else if (push && !full)    ptr_q <= ptr_q + PW'(1);
        else if (pop && !empty)    ptr_q <= ptr_q - PW'(1);
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_frame
        // Capture a new frame into slot g when it is the next free slot.
        always_ff @(posedge clk) begin
            if (push && !full && ptr_q == PW'(g)) begin
                par_q[g] <= push_par;
                alt_q[g] <= push_alt;
            end
        end
    end

    // Select the most recently pushed frame.
    always_comb begin
        top_par = '1;
        top_alt = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ptr_q == PW'(i + 1)) begin
                top_par = par_q[i];
                top_alt = alt_q[i];
            end
        end
    end

    AST_PUSH_THEN_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full) |=> (top_par == $past(push_par) && top_alt == $past(push_alt))); // R6
    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= PW'(DEPTH)); // R7
endmodule

// File: rtl/simd_mask_eval.sv
// Module: combinational opcode decoder; derives next mask, stack actions,
// same-cycle skip decisions and misuse events.
// Assumes: the top of stack inputs are valid whenever empty is low.
module simd_mask_eval
    import simd_mask_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic [2:0]       op,
    input  logic [LANES-1:0] mask,
    input  logic [LANES-1:0] cond,
    input  logic [LANES-1:0] top_par,
    input  logic [LANES-1:0] top_alt,
    input  logic             full,
    input  logic             empty,
    output logic [LANES-1:0] nxt_mask,
    output logic             push,
    output logic             pop,
    output logic [LANES-1:0] push_par,
    output logic [LANES-1:0] push_alt,
    output logic             skip_if,
    output logic             skip_else,
    output logic             loop_exit,
    output logic             misuse
);
    mask_op_e opc;
    assign opc = mask_op_e'(op);

    // Decode one opcode into mask update, stack action and skip flags.
    always_comb begin
        nxt_mask  = mask;
        push      = 1'b0;
        pop       = 1'b0;
        push_par  = mask;
        push_alt  = '0;
        skip_if   = 1'b0;
        skip_else = 1'b0;
        loop_exit = 1'b0;
        misuse    = 1'b0;
        unique case (opc)
            OP_IF: begin
                skip_if = ~|(mask & cond);
                if (full) misuse = 1'b1;
                else begin
                    push     = 1'b1;
                    push_alt = mask & ~cond;
                    nxt_mask = mask & cond;
                end
            end
            OP_ELSE: begin
                if (empty) misuse = 1'b1;
                else begin
                    nxt_mask  = top_alt;
                    skip_else = ~|top_alt;
                end
            end
            OP_ENDIF, OP_LOOP_END: begin
                if (empty) misuse = 1'b1;
                else begin
                    pop      = 1'b1;
                    nxt_mask = top_par;
                end
            end
            OP_LOOP_ENTER: begin
                if (full) misuse = 1'b1;
                else push = 1'b1;
            end
            OP_LOOP_TEST: begin
                nxt_mask  = mask & cond;
                loop_exit = ~|(mask & cond);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/simd_mask_ctrl.sv
// Module: top of the divergence mask controller. Holds the live mask and the
// sticky error flag; delegates decode and frame storage to its parts.
// Assumes: one opcode per cycle, structured (properly nested) programs.
module simd_mask_ctrl
    import simd_mask_pkg::*;
#(
    parameter int LANES = 16,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op,
    input  logic [LANES-1:0] cond,
    output logic [LANES-1:0] active_mask,
    output logic             skip_if,
    output logic             skip_else,
    output logic             loop_exit,
    output logic             stack_err
);
    logic [LANES-1:0] nxt_mask, top_par, top_alt, push_par, push_alt;
    logic             push, pop, full, empty, misuse;

    simd_mask_eval #(.LANES(LANES)) u_eval (
        .op(op), .mask(active_mask), .cond(cond),
        .top_par(top_par), .top_alt(top_alt), .full(full), .empty(empty),
        .nxt_mask(nxt_mask), .push(push), .pop(pop),
        .push_par(push_par), .push_alt(push_alt),
        .skip_if(skip_if), .skip_else(skip_else), .loop_exit(loop_exit),
        .misuse(misuse)
    );

    simd_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .push_par(push_par), .push_alt(push_alt),
        .top_par(top_par), .top_alt(top_alt), .full(full), .empty(empty)
    );

    // Register the live lane mask; reset enables every lane.
    always_ff @(posedge clk) begin
        if (!rst_n) active_mask <= '1;
        else        active_mask <= nxt_mask;
    end

    // Latch any stack misuse until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      stack_err <= 1'b0;
        else if (misuse) stack_err <= 1'b1;
    end

    AST_IF_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd1 && !full) |=> active_mask == $past(active_mask & cond)); // R2
    AST_LOOP_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd5) |=> (active_mask & ~$past(active_mask)) == '0); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        stack_err |=> stack_err); // R10
    AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == 3'd1 || op == 3'd4) && full) |=> (stack_err && active_mask == $past(active_mask))); // R10
    AST_NOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd0) |=> active_mask == $past(active_mask)); // R12
    AST_SKIP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({skip_if, skip_else, loop_exit})); // R3
endmodule

// File: tb/sim_simd_mask_ctrl.sv
module sim_simd_mask_ctrl;
    localparam int L = 16;
    localparam int D = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   op = 3'd0;
    logic [L-1:0] cond = '0;
    logic [L-1:0] active_mask;
    logic         skip_if, skip_else, loop_exit, stack_err;

    simd_mask_ctrl #(.LANES(L), .DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n), .op(op), .cond(cond),
        .active_mask(active_mask), .skip_if(skip_if), .skip_else(skip_else),
        .loop_exit(loop_exit), .stack_err(stack_err)
    );

    always #2 clk = ~clk;

    int total = 0;
    int bad = 0;

    // reference model
    logic [L-1:0] m_mask;
    logic [L-1:0] m_par [D];
    logic [L-1:0] m_alt [D];
    bit           m_loop [D];
    int           m_dep;
    bit           m_err;

    task automatic chk(input bit ok, input string req, input logic [L-1:0] act, input logic [L-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_mask = '1; m_dep = 0; m_err = 0;
    endtask

    // Apply one opcode: check same-cycle skips, then the registered state.
    task automatic step(input logic [2:0] o, input logic [L-1:0] c);
        bit e_si, e_se, e_le;
        logic [L-1:0] n;
        @(negedge clk);
        op = o; cond = c;
        e_si = 0; e_se = 0; e_le = 0; n = m_mask;
        case (o)
            3'd1: begin
                e_si = ((m_mask & c) == '0);
                if (m_dep == D) m_err = 1;
                else begin
                    m_par[m_dep] = m_mask; m_alt[m_dep] = m_mask & ~c;
                    m_loop[m_dep] = 0; m_dep++; n = m_mask & c;
                end
            end
            3'd2: begin
                if (m_dep == 0) m_err = 1;
                else begin n = m_alt[m_dep-1]; e_se = (n == '0); end
            end
            3'd3, 3'd6: begin
                if (m_dep == 0) m_err = 1;
                else begin m_dep--; n = m_par[m_dep]; end
            end
            3'd4: begin
                if (m_dep == D) m_err = 1;
                else begin
                    m_par[m_dep] = m_mask; m_alt[m_dep] = '0;
                    m_loop[m_dep] = 1; m_dep++;
                end
            end
            3'd5: begin n = m_mask & c; e_le = (n == '0); end
            default: ;
        endcase
        #1;
        chk(skip_if == e_si, "R3 skip_if", L'(skip_if), L'(e_si));
        chk(skip_else == e_se, "R5 skip_else", L'(skip_else), L'(e_se));
        chk(loop_exit == e_le, "R8 loop_exit", L'(loop_exit), L'(e_le));
        @(posedge clk); #1;
        m_mask = n;
        chk(active_mask == m_mask, "R2/R4/R6/R9 mask", active_mask, m_mask);
        chk(stack_err == m_err, "R10/R11 stack_err", L'(stack_err), L'(m_err));
    endtask

    // watchdog
    initial begin
        #600000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(active_mask == '1, "R1 mask", active_mask, '1);
        chk(stack_err == 1'b0, "R1 err", L'(stack_err), '0);
        chk(!skip_if && !skip_else && !loop_exit, "R1 skips", L'({skip_if, skip_else, loop_exit}), '0);

        // R3/R4/R5 directed: all lanes take else side
        step(3'd1, '0);
        step(3'd2, 16'h1234);          // R4 cond ignored at flip
        chk(active_mask == '1, "R4 flip full", active_mask, '1);
        step(3'd3, '0);                 // R6
        // all lanes take if side: else skipped (R5)
        step(3'd1, '1);
        step(3'd2, '0);
        step(3'd3, '0);
        // disagreement
        step(3'd1, 16'h00FF);
        step(3'd2, 16'hFFFF);
        chk(active_mask == 16'hFF00, "R4 disagree", active_mask, 16'hFF00);
        step(3'd3, '0);
        // R12 NOP and code 7
        step(3'd0, 16'hAAAA);
        step(3'd7, 16'h5555);
        // R8/R9 loop: lanes drop out until none left
        step(3'd4, '0);
        step(3'd5, 16'h0F0F);
        step(3'd5, 16'h0F00);
        step(3'd5, 16'h00F0);
        chk(active_mask == '0, "R8 loop drained", active_mask, '0);
        step(3'd6, '0);
        chk(active_mask == '1, "R9 loop restore", active_mask, '1);

        // randomized structured sequences (R7 nesting)
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [L-1:0] c;
            r = int'($urandom_range(0, 99));
            c = L'($urandom);
            if (r < 10) c = c | m_mask;
            else if (r < 20) c = c & ~m_mask;
            if (m_dep == 0 || (m_dep < D && r < 40)) begin
                step((r % 2 == 0) ? 3'd1 : 3'd4, c);
            end else if (!m_loop[m_dep-1]) begin
                step((r < 70) ? 3'd2 : 3'd3, c);
            end else begin
                step((r < 75) ? 3'd5 : 3'd6, c);
            end
        end
        while (m_dep > 0) step(m_loop[m_dep-1] ? 3'd6 : 3'd3, '0);
        chk(active_mask == '1, "R7 unwound", active_mask, '1);

        // R10 overflow coinciding with a same-cycle skip
        for (int k = 0; k < D; k++) step(3'd1, '1);
        step(3'd1, '0);
        chk(stack_err == 1'b1, "R10 overflow flag", L'(stack_err), L'(1));
        chk(active_mask == '1, "R10 mask frozen", active_mask, '1);
        step(3'd4, '0);
        for (int k = 0; k < D; k++) step(3'd3, '0);
        chk(stack_err == 1'b1, "R10 sticky", L'(stack_err), L'(1));

        // R11 underflow after reset
        @(negedge clk); rst_n = 1'b0; op = 3'd0;
        @(negedge clk); rst_n = 1'b1; model_reset();
        #1;
        chk(stack_err == 1'b0, "R1 err cleared", L'(stack_err), '0);
        step(3'd1, 16'h0001);
        step(3'd3, '0);
        step(3'd3, '0);
        chk(stack_err == 1'b1, "R11 underflow", L'(stack_err), L'(1));
        step(3'd2, 16'h00FF);
        step(3'd6, '0);
        chk(active_mask == '1, "R11 mask held", active_mask, '1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule